// File: doc/BRIEF.md
# Fractional Microsecond Tick Counter

This block turns a fast reference clock into a steady 1 MHz timing base. It does this even when the reference rate is not a whole multiple of 1 MHz. A 16-bit ratio word holds two fields: N, the number of ticks to issue, and M, the number of reference cycles in which to issue them. Both fields are stored as value minus one. An accumulator advances by N on every reference cycle. When it reaches M, it gives back M and raises a one-cycle tick strobe. This spreads the N ticks as evenly as whole cycles allow. For example, 12.8 MHz becomes 1 MHz with N=5 and M=64, and 38.4 MHz with N=5 and M=192.

Each tick advances a free-running 32-bit microsecond counter, which wraps on overflow. A small register port gives access to three things: the ratio word, the counter value (read at any time) and a freeze bit. While the freeze bit is set, both the strobe and the counter stop. Other timers on the chip use `tick_o` as their 1 MHz enable.

Top module: `utick_timer`

## Requirements
- R1: After reset the ratio word reads 0x000B, the counter reads 0, the freeze bit reads 0 and `tick_o` is low.
- R2: The ratio word is at register index 0. Bits [7:0] hold M-1 and bits [15:8] hold N-1. It reads back zero-extended to 32 bits, and written bits above bit 15 are discarded.
- R3: When N <= M, exactly N*W strobes occur in the W*M cycles that follow a ratio write.
- R4: When N < M, consecutive strobes are floor(M/N) or ceil(M/N) cycles apart.
- R5: A ratio write clears the accumulator. `tick_o` is low in the cycle after the write edge, and the first strobe comes ceil(M/N) cycles after that edge.
- R6: When N >= M, `tick_o` is high on every cycle after the write edge.
- R7: The counter is at register index 1. It increases by one for each strobe, one cycle after the strobe. It is read-only, so writes to index 1 leave it unchanged.
- R8: The freeze bit is bit 0 of register index 2. From the second cycle after it is set, `tick_o` stays low and the counter holds. Clearing it resumes counting from the held value.
- R9: Register index 3 reads zero, and writes to it change no other register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| tick_o | output | 1 | One-cycle 1 MHz tick strobe |

## Verification
The hardest condition to reach from the ports is the accumulator's phase: whether it was really cleared by a ratio write, since a leftover remainder barely changes the long-run strobe count. The stimulus lets a 1/12 ratio run five cycles past a window boundary, which leaves a known nonzero remainder. It then rewrites the same word and times the first strobe exactly. The fractional ratios are also checked gap by gap over whole windows, so a carry slip of one cycle shows up as a spacing error.

// File: rtl/utick_pkg.sv
package utick_pkg;

    // Register indices seen on the register port
    typedef enum logic [1:0] {
        ADDR_CFG    = 2'd0,
        ADDR_COUNT  = 2'd1,
        ADDR_FREEZE = 2'd2,
        ADDR_SPARE  = 2'd3
    } reg_sel_e;

    localparam int UTICK_FIELD_W = 8;
    localparam int UTICK_DATA_W  = 32;
    localparam int UTICK_COUNT_W = 32;

endpackage

// File: rtl/utick_regs.sv
module utick_regs
    import utick_pkg::*;
#(
    parameter int FIELD_W = UTICK_FIELD_W,
    parameter int DATA_W  = UTICK_DATA_W,
    parameter int COUNT_W = UTICK_COUNT_W,
    parameter logic [2*FIELD_W-1:0] CFG_RESET = 16'h000B
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [COUNT_W-1:0] count_i,
    output logic [DATA_W-1:0]  rdata,
    output logic [FIELD_W-1:0] n_m1_o,
    output logic [FIELD_W-1:0] m_m1_o,
    output logic               freeze_o,
    output logic               cfg_wr_o
);
    localparam int CFG_W = 2 * FIELD_W;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             freeze;
    } regs_t;

    regs_t    st_d, st_q;
    reg_sel_e sel;
    logic     unused_wdata_hi;

    assign sel             = reg_sel_e'(addr);
    assign unused_wdata_hi = ^wdata[DATA_W-1:CFG_W];

    always_comb begin
        st_d     = st_q;
        cfg_wr_o = 1'b0;
        if (wr_en) begin
            case (sel)
                ADDR_CFG: begin
                    st_d.cfg = wdata[CFG_W-1:0];
                    cfg_wr_o = 1'b1;
                end
                ADDR_FREEZE: st_d.freeze = wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            ADDR_CFG:    rdata = DATA_W'(st_q.cfg);
            ADDR_COUNT:  rdata = DATA_W'(count_i);
            ADDR_FREEZE: rdata = DATA_W'(st_q.freeze);
            default:     rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg    <= CFG_RESET;
            st_q.freeze <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_m1_o   = st_q.cfg[FIELD_W-1:0];
    assign n_m1_o   = st_q.cfg[CFG_W-1:FIELD_W];
    assign freeze_o = st_q.freeze;

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && (addr == ADDR_CFG)) |-> $stable({n_m1_o, m_m1_o}));

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && (addr == ADDR_FREEZE)) |-> $stable(freeze_o));

endmodule

// File: rtl/utick_ratio_acc.sv
module utick_ratio_acc #(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               freeze_i,
    input  logic [FIELD_W-1:0] n_m1_i,
    input  logic [FIELD_W-1:0] m_m1_i,
    output logic               tick_o
);
    localparam int ACC_W = FIELD_W + 2;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } acc_t;

    acc_t             st_d, st_q;
    logic [ACC_W-1:0] n_val, m_val, sum;

    always_comb begin
        n_val = ACC_W'(n_m1_i) + ACC_W'(1);
        m_val = ACC_W'(m_m1_i) + ACC_W'(1);
        sum   = st_q.acc + n_val;
        st_d  = st_q;
        if (clr_i) begin
            st_d.acc  = '0;
            st_d.tick = 1'b0;
        end else if (freeze_i) begin
            st_d.tick = 1'b0;
        end else if (n_val >= m_val) begin
            st_d.acc  = '0;
            st_d.tick = 1'b1;
        end else if (sum >= m_val) begin
            st_d.acc  = sum - m_val;
            st_d.tick = 1'b1;
        end else begin
            st_d.acc  = sum;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

    // R3
    acc_lt_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc < (ACC_W'(m_m1_i) + ACC_W'(1)));

    // R8
    frozen_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(freeze_i) |-> !tick_o);

    // R6
    sat_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!clr_i && !freeze_i && (n_m1_i >= m_m1_i)) |-> tick_o);

endmodule

// File: rtl/utick_counter.sv
module utick_counter #(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    output logic [COUNT_W-1:0] count_o
);
    typedef struct packed {
        logic [COUNT_W-1:0] count;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.count = st_q.count + COUNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick_i) |-> (count_o == $past(count_o) + COUNT_W'(1)));

    // R7
    count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_i) |-> $stable(count_o));

endmodule

// File: rtl/utick_timer.sv
module utick_timer
    import utick_pkg::*;
#(
    parameter int FIELD_W = UTICK_FIELD_W,
    parameter int DATA_W  = UTICK_DATA_W,
    parameter int COUNT_W = UTICK_COUNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tick_o
);
    logic [FIELD_W-1:0] n_m1, m_m1;
    logic               freeze, cfg_wr;
    logic [COUNT_W-1:0] count;

    utick_regs #(
        .FIELD_W (FIELD_W),
        .DATA_W  (DATA_W),
        .COUNT_W (COUNT_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .count_i  (count),
        .rdata    (reg_rdata),
        .n_m1_o   (n_m1),
        .m_m1_o   (m_m1),
        .freeze_o (freeze),
        .cfg_wr_o (cfg_wr)
    );

    utick_ratio_acc #(
        .FIELD_W (FIELD_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (cfg_wr),
        .freeze_i (freeze),
        .n_m1_i   (n_m1),
        .m_m1_i   (m_m1),
        .tick_o   (tick_o)
    );

    utick_counter #(
        .COUNT_W (COUNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_o),
        .count_o (count)
    );

    // R5
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr && (reg_addr == ADDR_CFG)) |-> !tick_o);

endmodule

// File: tb/utick_timer_bench.sv
module utick_timer_bench;
    import utick_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick_o;

    int checks = 0;
    int errors = 0;
    longint tick_total = 0;

    always #10 clk = ~clk;

    utick_timer u_utick_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tick_o    (tick_o)
    );

    always @(negedge clk) if (rst_n && tick_o) tick_total++;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #2;
        v = reg_rdata;
    endtask

    task automatic check_count(input string req);
        logic [31:0] v;
        longint exp;
        read_reg(ADDR_COUNT, v);
        exp = tick_total - (tick_o ? 1 : 0);
        chk(v == exp[31:0], req, "counter vs strobes", v, exp);
    endtask

    task automatic test_reset();
        logic [31:0] v;
        read_reg(ADDR_CFG, v);    chk(v == 32'h000B, "R1", "ratio word", v, 32'h000B);
        read_reg(ADDR_COUNT, v);  chk(v == 0, "R1", "counter", v, 0);
        read_reg(ADDR_FREEZE, v); chk(v == 0, "R1", "freeze", v, 0);
        chk(tick_o == 1'b0, "R1", "strobe", tick_o, 0);
    endtask

    task automatic run_ratio(input logic [15:0] word, input int n, input int m,
                             input int windows);
        int ticks = 0, first = 0, last = 0, lo, hi, bad_gap = 0, total;
        bit sat = (n >= m);
        string rq = sat ? "R6" : "R3";
        write_reg(ADDR_CFG, {16'h0, word});
        #2;
        chk(tick_o == 1'b0, "R5", "strobe after ratio write", tick_o, 0);
        lo = sat ? 1 : m / n;
        hi = sat ? 1 : (m + n - 1) / n;
        total = windows * m;
        for (int c = 1; c <= total; c++) begin
            @(negedge clk); #2;
            if (tick_o) begin
                ticks++;
                if (first == 0) first = c;
                else if ((c - last) < lo || (c - last) > hi) bad_gap = c - last;
                last = c;
            end
        end
        chk(ticks == (sat ? total : n * windows), rq, "strobes per window",
            ticks, sat ? total : n * windows);
        chk(first == hi, "R5", "first strobe cycle", first, hi);
        chk(bad_gap == 0, "R4", "strobe spacing", bad_gap, lo);
        check_count("R7");
    endtask

    task automatic test_clear();
        run_ratio(16'h000B, 1, 12, 1);
        repeat (5) @(negedge clk);
        run_ratio(16'h000B, 1, 12, 2);
    endtask

    task automatic test_freeze();
        logic [31:0] c0, c1, v;
        bit quiet = 1'b1;
        write_reg(ADDR_CFG, 32'h0000_000B);
        repeat (30) @(negedge clk);
        write_reg(ADDR_FREEZE, 32'h1);
        @(negedge clk);
        read_reg(ADDR_COUNT, c0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #2;
            if (tick_o) quiet = 1'b0;
        end
        read_reg(ADDR_COUNT, c1);
        chk(quiet, "R8", "strobe while frozen", !quiet, 0);
        chk(c1 == c0, "R8", "counter held", c1, c0);
        read_reg(ADDR_FREEZE, v);
        chk(v == 1, "R8", "freeze readback", v, 1);
        write_reg(ADDR_FREEZE, 32'h0);
        repeat (30) @(negedge clk);
        read_reg(ADDR_COUNT, c1);
        chk(c1 > c0, "R8", "counting resumed", c1, c0 + 1);
        check_count("R8");
    endtask

    task automatic test_map();
        logic [31:0] v;
        write_reg(ADDR_CFG, 32'hABCD_043F);
        read_reg(ADDR_CFG, v);
        chk(v == 32'h0000_043F, "R2", "upper bits dropped", v, 32'h043F);
        write_reg(ADDR_COUNT, 32'hDEAD_BEEF);
        check_count("R7");
        write_reg(ADDR_SPARE, 32'hFFFF_FFFF);
        read_reg(ADDR_SPARE, v);
        chk(v == 0, "R9", "spare index reads zero", v, 0);
        read_reg(ADDR_CFG, v);
        chk(v == 32'h0000_043F, "R9", "ratio word untouched", v, 32'h043F);
        read_reg(ADDR_FREEZE, v);
        chk(v == 0, "R9", "freeze untouched", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_ratio(16'h000B, 1, 12, 10);
        run_ratio(16'h043F, 5, 64, 4);
        run_ratio(16'h002F, 1, 48, 3);
        run_ratio(16'h04BF, 5, 192, 2);
        run_ratio(16'h0703, 8, 4, 5);
        run_ratio(16'h0505, 6, 6, 3);
        test_clear();
        test_freeze();
        test_map();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule